// File: doc/BRIEF.md
# Banked Integer Register File with Shadow Set

This block holds the integer registers of a 32-bit load/store processor core. It keeps two complete sets of thirty-two 32-bit registers. The first is the primary set. The second is a shadow set that an interrupt or exception handler can switch to, so that it does not have to spill and refill the interrupted context.

The block has two combinational read ports and one write port that updates on the clock edge. A write is forwarded internally to either read port in the same cycle, so an instruction that reads a register while it is being written sees the new value. The read side and the write side each have their own set-select input. Forwarding happens only when both the set and the register index agree. The surrounding control decides when to switch sets; this block only follows the select inputs.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous reset, every register in both sets reads as zero.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored in register `wr_idx` of set `wr_set`. From the next cycle on, port A returns that value when it addresses that set and index.
- R3: Port B returns stored values on the same terms as port A, independently of port A's address.
- R4: Register index 0 reads as zero in every set. A write to index 0 changes nothing and is not forwarded.
- R5: When a write is live in a cycle, a read port that addresses the same set and index returns `wr_data` in that same cycle, before the edge.
- R6: A write to one set is not forwarded to a read of the other set, even when the index matches. The read returns the value already stored there.
- R7: The two sets are independent. A write to an index in one set leaves the same index in the other set unchanged.
- R8: When `wr_en` is low, no register changes at the edge, whatever `wr_data`, `wr_set` and `wr_idx` hold.
- R9: Reset has priority over a write in the same cycle. Such a write is neither stored nor forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears both sets |
| rd_set | input | 1 | Set used by both read ports (0 primary, 1 shadow) |
| ra_idx | input | 5 | Port A register index |
| ra_data | output | 32 | Port A read data (combinational) |
| rb_idx | input | 5 | Port B register index |
| rb_data | output | 32 | Port B read data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_set | input | 1 | Set written (0 primary, 1 shadow) |
| wr_idx | input | 5 | Register index written |
| wr_data | input | 32 | Data written |

## Verification
The hardest case to reach from the ports is a write and a read in the same cycle that share an index but differ in set. In that cycle the forwarded data must lose to the stored value of the other set. Because the two sets hold different values, a wrong choice shows up on the output. Random traffic rarely lines up the index while the sets differ, so a directed sequence first gives the two sets different contents at one index. It then writes that index in one set while reading it from the other. The random phase draws the set selects and indices from a narrow range so that such collisions keep recurring.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int RF_DATA_W = 32;
  localparam int RF_NREGS  = 32;
  localparam int RF_NSETS  = 2;

  // A write counts only outside reset and when it targets a real register.
  function automatic logic write_live(input logic en, input logic rst,
                                      input int unsigned idx);
    return en && !rst && (idx != 0);
  endfunction

  // Forwarding condition: a live write at the same set and index.
  function automatic logic lane_match(input logic live,
                                      input int unsigned wset, input int unsigned widx,
                                      input int unsigned rset, input int unsigned ridx);
    return live && (wset == rset) && (widx == ridx);
  endfunction
endpackage

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int NREGS  = rf_pkg::RF_NREGS,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NREGS-1:0][DATA_W-1:0]  regs_q
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign regs_q[r] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wr_en && (wr_idx == IDX_W'(r)))
          q <= wr_data;
      end
      assign regs_q[r] = q;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int NREGS  = rf_pkg::RF_NREGS,
  parameter int NSETS  = rf_pkg::RF_NSETS,
  localparam int IDX_W = $clog2(NREGS),
  localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic [NSETS-1:0][NREGS-1:0][DATA_W-1:0] sets_q,
  input  logic [SET_W-1:0]                        rd_set,
  input  logic [IDX_W-1:0]                        rd_idx,
  input  logic                                    wr_live,
  input  logic [SET_W-1:0]                        wr_set,
  input  logic [IDX_W-1:0]                        wr_idx,
  input  logic [DATA_W-1:0]                       wr_data,
  output logic [DATA_W-1:0]                       rd_data,
  output logic                                    hit
);
  logic [DATA_W-1:0] stored;

  always_comb begin
    stored  = sets_q[rd_set][rd_idx];
    hit     = rf_pkg::lane_match(wr_live, 32'(wr_set), 32'(wr_idx),
                                 32'(rd_set), 32'(rd_idx));
    rd_data = hit ? wr_data : stored;
  end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile #(
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int NREGS  = rf_pkg::RF_NREGS,
  parameter int NSETS  = rf_pkg::RF_NSETS,
  localparam int IDX_W = $clog2(NREGS),
  localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  // Named internal events, brought out for the checker.
  logic wr_live;
  logic hit_a;
  logic hit_b;

  logic [NSETS-1:0][NREGS-1:0][DATA_W-1:0] sets_q;

  assign wr_live = rf_pkg::write_live(wr_en, rst, 32'(wr_idx));

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic set_wr;
    assign set_wr = wr_live && (wr_set == SET_W'(s));
    rf_bank #(.DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (set_wr),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .regs_q  (sets_q[s])
    );
  end

  rf_read_port #(.DATA_W(DATA_W), .NREGS(NREGS), .NSETS(NSETS)) u_port_a (
    .sets_q  (sets_q),
    .rd_set  (rd_set),
    .rd_idx  (ra_idx),
    .wr_live (wr_live),
    .wr_set  (wr_set),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_data (ra_data),
    .hit     (hit_a)
  );

  rf_read_port #(.DATA_W(DATA_W), .NREGS(NREGS), .NSETS(NSETS)) u_port_b (
    .sets_q  (sets_q),
    .rd_set  (rd_set),
    .rd_idx  (rb_idx),
    .wr_live (wr_live),
    .wr_set  (wr_set),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_data (rb_data),
    .hit     (hit_b)
  );
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int SET_W  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [SET_W-1:0]  rd_set,
  input logic [IDX_W-1:0]  ra_idx,
  input logic [DATA_W-1:0] ra_data,
  input logic [IDX_W-1:0]  rb_idx,
  input logic [DATA_W-1:0] rb_data,
  input logic              wr_en,
  input logic [SET_W-1:0]  wr_set,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_live,
  input logic              hit_a,
  input logic              hit_b
);
  a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !hit_a) |-> (ra_data == '0));

  a_r2_write_lands_a: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_live) && rd_set == $past(wr_set) && ra_idx == $past(wr_idx) && !hit_a)
      |-> (ra_data == $past(wr_data)));

  a_r3_write_lands_b: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_live) && rd_set == $past(wr_set) && rb_idx == $past(wr_idx) && !hit_b)
      |-> (rb_data == $past(wr_data)));

  a_r4_zero_a: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == '0) |-> (ra_data == '0));

  a_r4_zero_b: assert property (@(posedge clk) disable iff (rst)
    (rb_idx == '0) |-> (rb_data == '0));

  a_r5_forward_a: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && wr_set == rd_set && wr_idx == ra_idx) |-> (ra_data == wr_data));

  a_r5_forward_b: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && wr_set == rd_set && wr_idx == rb_idx) |-> (rb_data == wr_data));

  a_r6_no_cross_set: assert property (@(posedge clk) disable iff (rst)
    (hit_a || hit_b) |-> (wr_set == rd_set));

  a_r9_reset_blocks_write: assert property (@(posedge clk)
    rst |-> !wr_live);
endmodule

bind banked_regfile rf_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SET_W(SET_W)) u_rf_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_set  (rd_set),
  .ra_idx  (ra_idx),
  .ra_data (ra_data),
  .rb_idx  (rb_idx),
  .rb_data (rb_data),
  .wr_en   (wr_en),
  .wr_set  (wr_set),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .wr_live (wr_live),
  .hit_a   (hit_a),
  .hit_b   (hit_b)
);

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        rd_set;
  logic [4:0]  ra_idx, rb_idx, wr_idx;
  logic [31:0] ra_data, rb_data, wr_data;
  logic        wr_en, wr_set;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model [2][32];

  always #5 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst(rst), .rd_set(rd_set),
    .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_set(wr_set), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // Expected read: forward a live write at the same set and index, else the model.
  function automatic logic [31:0] expect_rd(input logic s, input logic [4:0] i);
    if (!rst && wr_en && wr_idx != 5'd0 && wr_set == s && wr_idx == i)
      return wr_data;
    return model[s][i];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check before the rising edge,
  // then commit the model as the design will at that edge.
  task automatic step(input string tag, input logic r, input logic we,
                      input logic ws, input logic [4:0] wi, input logic [31:0] wd,
                      input logic rs, input logic [4:0] ia, input logic [4:0] ib,
                      input bit do_check);
    @(negedge clk);
    rst = r; wr_en = we; wr_set = ws; wr_idx = wi; wr_data = wd;
    rd_set = rs; ra_idx = ia; rb_idx = ib;
    #2;
    if (do_check && !r) begin
      check(tag, "port A", ra_data, expect_rd(rs, ia));
      check(tag, "port B", rb_data, expect_rd(rs, ib));
    end
    if (r) begin
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 32; i++) model[s][i] = 32'd0;
    end else if (we && wi != 5'd0) begin
      model[ws][wi] = wd;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 1'b0; wr_set = 1'b0; wr_idx = '0; wr_data = '0;
    rd_set = 1'b0; ra_idx = '0; rb_idx = '0;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 32; i++) model[s][i] = 32'd0;

    // R9: write attempted while reset is high
    step("R9", 1'b1, 1'b1, 1'b0, 5'd5, 32'hDEAD_BEEF, 1'b0, 5'd5, 5'd5, 1'b0);
    step("R9", 1'b1, 1'b1, 1'b1, 5'd9, 32'hCAFE_0009, 1'b0, 5'd0, 5'd0, 1'b0);
    // R1: every register of both sets reads zero after reset
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 32; i += 2)
        step("R1", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, s[0], i[4:0], 5'(i + 1), 1'b1);
    step("R9", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd5, 5'd5, 1'b1);
    step("R9", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 5'd9, 5'd9, 1'b1);

    // R2 / R3: write then read on each port
    step("R2", 1'b0, 1'b1, 1'b0, 5'd3, 32'h1111_2222, 1'b0, 5'd0, 5'd0, 1'b1);
    step("R2", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd3, 5'd0, 1'b1);
    step("R3", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd1, 5'd3, 1'b1);

    // R4: write to index 0 is neither forwarded nor stored
    step("R4", 1'b0, 1'b1, 1'b1, 5'd0, 32'hFFFF_FFFF, 1'b1, 5'd0, 5'd0, 1'b1);
    step("R4", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 5'd0, 5'd0, 1'b1);

    // R5: same-cycle forwarding to both ports in the shadow set
    step("R5", 1'b0, 1'b1, 1'b1, 5'd7, 32'hAAAA_0007, 1'b1, 5'd7, 5'd7, 1'b1);
    // R6: write set 0 index 7 while reading set 1 index 7 -> stored shadow value
    step("R6", 1'b0, 1'b1, 1'b0, 5'd7, 32'h5555_0007, 1'b1, 5'd7, 5'd7, 1'b1);
    // R7: both sets keep their own index 7
    step("R7", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd7, 5'd3, 1'b1);
    step("R7", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 5'd7, 5'd3, 1'b1);
    // R8: disabled write leaves the register unchanged
    step("R8", 1'b0, 1'b0, 1'b1, 5'd7, 32'h0BAD_0BAD, 1'b1, 5'd0, 5'd0, 1'b1);
    step("R8", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 5'd7, 5'd7, 1'b1);

    // Random traffic on a narrow index range to force collisions (R2, R3, R5, R6, R7)
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wi, ia, ib;
      wi = 5'($urandom_range(0, 7));
      ia = 5'($urandom_range(0, 7));
      ib = 5'($urandom_range(0, 7));
      step("R5", 1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), wi, $urandom(),
           1'($urandom_range(0, 1)), ia, ib, 1'b1);
    end

    // R1 again: mid-run reset clears everything
    step("R1", 1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd0, 5'd0, 1'b0);
    for (int i = 1; i < 8; i++)
      step("R1", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, i[0], i[4:0], 5'(i), 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule